// File: doc/BRIEF.md
# DDR2 Burst Latency and Interrupt Tracker

This block watches the command stream that a memory controller sends to a DDR2-style device and works out, clock by clock, when read data and write data occupy the data bus. It adds the additive latency and the CAS latency to get the read latency, and takes one clock less for writes. Each accepted command is sent down a short delay line. When the command comes out, a read-window or write-window generator opens and counts the bus clocks of the burst. At two beats per clock, a 4-beat burst takes 2 clocks and an 8-beat burst takes 4.

The block also checks the rules for cutting a burst short. A command that arrives before the previous burst's issue slot has elapsed counts as an interruption. With 4-beat bursts no interruption is legal. With 8-beat bursts a read may cut off a read and a write may cut off a write, and the newer burst replaces the tail of the older one. A forbidden interruption is dropped and sets a sticky flag. The controller or a monitor uses the windows to steer capture and drive logic, and uses the flag to catch sequencing bugs.

Top module: `ddr2_burst_tracker`

## Requirements
- R1: A READ (cmd_i = 2'b01) accepted at clock edge k raises rd_valid_o starting from edge k+RL, where RL = al_i + cl_i; al_i is held within 0..4 and cl_i within 3..6.
- R2: A WRITE (cmd_i = 2'b10) accepted at edge k raises wr_valid_o starting from edge k+RL-1.
- R3: A window lasts 2 clocks when bl8_i = 0 (4 beats) and 4 clocks when bl8_i = 1 (8 beats). The beat output is 0 in the first clock of the window and rises by one each clock.
- R4: Same-type commands issued exactly one burst length apart (2 or 4 clocks) give one unbroken valid window, and the beat index restarts at 0 for the second burst.
- R5: With bl8_i = 0, a READ or WRITE that comes fewer than 2 clocks after the last accepted command is ignored and sets illegal_o. The earlier burst still gives its full 2-clock window.
- R6: With bl8_i = 1, a READ that comes fewer than 4 clocks after an accepted READ is accepted, and likewise a WRITE after a WRITE. The old window ends where the new window starts, and the new window starts at its own latency with beat 0.
- R7: With bl8_i = 1, a command of the other type that comes fewer than 4 clocks after the last accepted command is ignored and sets illegal_o.
- R8: illegal_o rises the edge after the first forbidden interruption and stays high until reset.
- R9: While rst_ni is low, all outputs are 0.
- R10: cmd_i = 2'b00 (NOP) and 2'b11 (reserved) start no burst and never set illegal_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 2 | Command code: 00 NOP, 01 READ, 10 WRITE, 11 reserved |
| al_i | input | 3 | Additive latency, 0..4 |
| cl_i | input | 3 | CAS latency, 3..6 |
| bl8_i | input | 1 | Burst length select: 0 = 4 beats, 1 = 8 beats |
| rd_valid_o | output | 1 | Read data occupies the bus in this clock |
| rd_beat_o | output | 2 | Clock index within the read window |
| wr_valid_o | output | 1 | Write data occupies the bus in this clock |
| wr_beat_o | output | 2 | Clock index within the write window |
| illegal_o | output | 1 | Sticky forbidden-interruption flag |

## Verification
The assertions assume that al_i, cl_i and bl8_i stay constant while any command is in flight. The window and beat checks rely on the burst length not changing while a window is open. The bench meets this by changing the configuration only while reset is held and otherwise leaving it alone. Each random phase picks al_i from 0..4, cl_i from 3..6 and a random burst length. It then drives a mix of NOP, READ, WRITE and reserved codes, so legal and illegal interruptions both occur. Directed phases drive the exact spacings that R4 through R7 describe.

// File: rtl/ddr2_bt_pkg.sv
package ddr2_bt_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_RSV = 2'b11
  } cmd_e;

  localparam int unsigned AL_MAX     = 4;
  localparam int unsigned CL_MIN     = 3;
  localparam int unsigned CL_MAX     = 6;
  localparam int unsigned RL_MAX     = AL_MAX + CL_MAX;
  localparam int unsigned BURST_CLKS = 4;  // clocks of an 8-beat burst
endpackage

// File: rtl/ddr2_issue_guard.sv
module ddr2_issue_guard
  import ddr2_bt_pkg::*;
#(
  parameter int unsigned BMAX = BURST_CLKS
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cmd_i,
  input  logic       bl8_i,
  output logic       acc_rd_o,
  output logic       acc_wr_o,
  output logic       illegal_o
);
  localparam int unsigned CW = $clog2(BMAX);
  localparam logic [CW-1:0] LAST8 = CW'(BMAX - 1);
  localparam logic [CW-1:0] LAST4 = CW'(BMAX / 2 - 1);

  logic [CW-1:0] busy_q;
  logic          last_rd_q;
  logic          ill_q;
  logic          is_rd, is_wr, busy, same, ok, bad;

  always_comb begin
    is_rd = (cmd_i == CMD_RD);
    is_wr = (cmd_i == CMD_WR);
    busy  = (busy_q != '0);
    same  = (is_rd && last_rd_q) || (is_wr && !last_rd_q);
    ok    = !busy || (bl8_i && same);
    bad   = (is_rd || is_wr) && !ok;
  end

  assign acc_rd_o  = is_rd && ok;
  assign acc_wr_o  = is_wr && ok;
  assign illegal_o = ill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= '0;
      last_rd_q <= 1'b0;
      ill_q     <= 1'b0;
    end else begin
      if (acc_rd_o || acc_wr_o) begin
        busy_q    <= bl8_i ? LAST8 : LAST4;
        last_rd_q <= is_rd;
      end else if (busy) begin
        busy_q <= busy_q - 1'b1;
      end
      if (bad) ill_q <= 1'b1;
    end
  end

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ill_q |=> ill_q);
  a_r5_bl4_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !bl8_i && (is_rd || is_wr)) |=> ill_q);
endmodule

// File: rtl/ddr2_lat_pipe.sv
module ddr2_lat_pipe #(
  parameter int unsigned DEPTH = 10,
  localparam int unsigned TW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_i,
  input  logic [TW-1:0] tap_i,
  output logic          out_o
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[DEPTH-2:0], in_i};
  end

  always_comb begin
    out_o = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (tap_i == TW'(i)) out_o = sr_q[i];
  end
endmodule

// File: rtl/ddr2_burst_gen.sv
module ddr2_burst_gen #(
  parameter int unsigned BMAX = 4,
  localparam int unsigned BW = $clog2(BMAX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bl8_i,
  output logic          valid_o,
  output logic [BW-1:0] beat_o
);
  logic [BW-1:0] last;
  logic          act_q;
  logic [BW-1:0] beat_q;

  assign last    = bl8_i ? BW'(BMAX - 1) : BW'(BMAX / 2 - 1);
  assign valid_o = act_q;
  assign beat_o  = act_q ? beat_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      beat_q <= '0;
    end else if (start_i) begin  // newer burst replaces any open one
      act_q  <= 1'b1;
      beat_q <= '0;
    end else if (act_q) begin
      if (beat_q == last) act_q <= 1'b0;
      else                beat_q <= beat_q + 1'b1;
    end
  end

  a_r3_beat_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (beat_o <= last));
  a_r3_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (beat_o == '0));
  a_r3_full_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> ($past(beat_o) == last));
  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && beat_o == '0));
endmodule

// File: rtl/ddr2_burst_tracker.sv
module ddr2_burst_tracker
  import ddr2_bt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cmd_i,
  input  logic [2:0] al_i,
  input  logic [2:0] cl_i,
  input  logic       bl8_i,
  output logic       rd_valid_o,
  output logic [1:0] rd_beat_o,
  output logic       wr_valid_o,
  output logic [1:0] wr_beat_o,
  output logic       illegal_o
);
  localparam int unsigned DEPTH = RL_MAX;
  localparam int unsigned TW    = $clog2(DEPTH);
  localparam int unsigned LW    = $clog2(RL_MAX + 1);

  logic [2:0]    al_c, cl_c;
  logic [LW-1:0] rl;
  logic [TW-1:0] tap_rd, tap_wr;
  logic          acc_rd, acc_wr, st_rd, st_wr;

  always_comb begin
    al_c   = (al_i > 3'(AL_MAX)) ? 3'(AL_MAX) : al_i;
    cl_c   = (cl_i < 3'(CL_MIN)) ? 3'(CL_MIN) :
             (cl_i > 3'(CL_MAX)) ? 3'(CL_MAX) : cl_i;
    rl     = LW'(al_c) + LW'(cl_c);
    tap_rd = TW'(rl - LW'(1));  // stage index = latency - 1
    tap_wr = TW'(rl - LW'(2));
  end

  ddr2_issue_guard #(.BMAX(BURST_CLKS)) u_guard (
    .clk_i, .rst_ni, .cmd_i, .bl8_i,
    .acc_rd_o(acc_rd), .acc_wr_o(acc_wr), .illegal_o
  );

  ddr2_lat_pipe #(.DEPTH(DEPTH)) u_pipe_rd (
    .clk_i, .rst_ni, .in_i(acc_rd), .tap_i(tap_rd), .out_o(st_rd)
  );
  ddr2_lat_pipe #(.DEPTH(DEPTH)) u_pipe_wr (
    .clk_i, .rst_ni, .in_i(acc_wr), .tap_i(tap_wr), .out_o(st_wr)
  );

  ddr2_burst_gen #(.BMAX(BURST_CLKS)) u_gen_rd (
    .clk_i, .rst_ni, .start_i(st_rd), .bl8_i,
    .valid_o(rd_valid_o), .beat_o(rd_beat_o)
  );
  ddr2_burst_gen #(.BMAX(BURST_CLKS)) u_gen_wr (
    .clk_i, .rst_ni, .start_i(st_wr), .bl8_i,
    .valid_o(wr_valid_o), .beat_o(wr_beat_o)
  );

  a_r10_reserved_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_RSV || cmd_i == CMD_NOP) |-> (!acc_rd && !acc_wr));
  a_r7_one_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_rd && acc_wr));
endmodule

// File: tb/ddr2_burst_tracker_bench.sv
module ddr2_burst_tracker_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cmd_i = 2'b00;
  logic [2:0] al_i = 3'd0, cl_i = 3'd3;
  logic       bl8_i = 1'b0;
  logic       rd_valid_o, wr_valid_o, illegal_o;
  logic [1:0] rd_beat_o, wr_beat_o;

  always #5 clk_i = ~clk_i;

  ddr2_burst_tracker u_ddr2_burst_tracker (.*);

  int checks = 0, fails = 0;
  int unsigned e = 0;
  bit exp_rdv[32], exp_wrv[32];
  int exp_rdi[32], exp_wri[32];
  bit m_any, m_last_rd, m_ill;
  int unsigned m_last_edge, m_ill_edge;
  int obs_rd, obs_wr;

  function automatic int nclk(bit b8);
    return b8 ? 4 : 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at edge %0d: actual=%0d expected=%0d", req, e, act, exp);
    end
  endtask

  task automatic model(logic [1:0] c, int unsigned k);
    bit isrd, busy, ok;
    int lat;
    if (c == 2'b01 || c == 2'b10) begin
      isrd = (c == 2'b01);
      busy = m_any && (k - m_last_edge < nclk(bl8_i));
      ok   = !busy || (bl8_i && (isrd == m_last_rd));
      if (ok) begin
        m_any = 1; m_last_edge = k; m_last_rd = isrd;
        lat = int'(al_i) + int'(cl_i) - (isrd ? 0 : 1);
        for (int j = 0; j < nclk(bl8_i); j++) begin
          if (isrd) begin exp_rdv[(k+lat+j)%32] = 1; exp_rdi[(k+lat+j)%32] = j; end
          else      begin exp_wrv[(k+lat+j)%32] = 1; exp_wri[(k+lat+j)%32] = j; end
        end
      end else if (!m_ill) begin
        m_ill = 1; m_ill_edge = k;
      end
    end
  endtask

  task automatic check_now();
    int s = e % 32;
    chk(rd_valid_o == exp_rdv[s], "R1 rd_valid", rd_valid_o, exp_rdv[s]);
    if (exp_rdv[s]) chk(rd_beat_o == exp_rdi[s], "R3 rd_beat", rd_beat_o, exp_rdi[s]);
    chk(wr_valid_o == exp_wrv[s], "R2 wr_valid", wr_valid_o, exp_wrv[s]);
    if (exp_wrv[s]) chk(wr_beat_o == exp_wri[s], "R3 wr_beat", wr_beat_o, exp_wri[s]);
    chk(illegal_o == (m_ill && e >= m_ill_edge), "R8 illegal", illegal_o,
        int'(m_ill && e >= m_ill_edge));
    if (rd_valid_o) obs_rd++;
    if (wr_valid_o) obs_wr++;
    exp_rdv[s] = 0; exp_wrv[s] = 0;
  endtask

  task automatic step(logic [1:0] c);
    check_now();
    cmd_i = c;
    model(c, e + 1);
    @(posedge clk_i);
    @(negedge clk_i);
    e++;
  endtask

  task automatic do_reset(int al, int cl, bit b8);
    @(negedge clk_i);
    rst_ni = 0; cmd_i = 2'b00;
    al_i = 3'(al); cl_i = 3'(cl); bl8_i = b8;
    for (int i = 0; i < 32; i++) begin exp_rdv[i] = 0; exp_wrv[i] = 0; end
    m_any = 0; m_ill = 0; obs_rd = 0; obs_wr = 0;
    @(negedge clk_i);
    chk(!rd_valid_o && !wr_valid_o && !illegal_o && rd_beat_o == 0 && wr_beat_o == 0,
        "R9 reset outputs", {rd_valid_o, wr_valid_o, illegal_o}, 0);
    rst_ni = 1;
  endtask

  task automatic drain();
    for (int i = 0; i < 16; i++) step(2'b00);
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R1 R2: AL=2 CL=3, BL4
    do_reset(2, 3, 0);
    step(2'b01); for (int i = 0; i < 8; i++) step(2'b00); step(2'b10); drain();
    chk(obs_rd == 2 && obs_wr == 2, "R3 bl4 window", obs_rd + obs_wr, 4);
    // R1 R2: AL=0 CL=3, BL8
    do_reset(0, 3, 1);
    step(2'b10); for (int i = 0; i < 8; i++) step(2'b00); step(2'b01); drain();
    chk(obs_rd == 4 && obs_wr == 4, "R3 bl8 window", obs_rd + obs_wr, 8);
    // R4 seamless reads, BL4 spacing 2
    do_reset(1, 4, 0);
    step(2'b01); step(2'b00); step(2'b01); drain();
    chk(obs_rd == 4 && !illegal_o, "R4 seamless", obs_rd, 4);
    // R5 BL4 interrupt by write
    do_reset(0, 5, 0);
    step(2'b01); step(2'b10); drain();
    chk(obs_rd == 2 && obs_wr == 0 && illegal_o, "R5 bl4 interrupt", obs_rd * 10 + obs_wr, 20);
    // R6 BL8 read cut by read after 2 clocks
    do_reset(3, 3, 1);
    step(2'b01); step(2'b00); step(2'b01); drain();
    chk(obs_rd == 6 && !illegal_o, "R6 bl8 same-type cut", obs_rd, 6);
    // R7 BL8 read cut by write
    do_reset(4, 6, 1);
    step(2'b01); step(2'b10); drain();
    chk(obs_rd == 4 && obs_wr == 0 && illegal_o, "R7 bl8 cross cut", obs_rd * 10 + obs_wr, 40);
    // R10 reserved and NOP codes
    do_reset(2, 4, 0);
    for (int i = 0; i < 6; i++) step(2'b11);
    drain();
    chk(obs_rd == 0 && obs_wr == 0 && !illegal_o, "R10 reserved code", obs_rd + obs_wr, 0);
    // random phases
    for (int p = 0; p < 24; p++) begin
      do_reset($urandom_range(4, 0), $urandom_range(6, 3), 1'($urandom_range(1, 0)));
      for (int i = 0; i < 150; i++) begin
        int r = $urandom_range(99, 0);
        step(r < 60 ? 2'b00 : r < 78 ? 2'b01 : r < 96 ? 2'b10 : 2'b11);
      end
      drain();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule